// File: doc/BRIEF.md
# SD card clock generator

This block turns the kernel clock into the clock that is sent to an SD or MMC card. It also produces a one-cycle launch strobe that tells the command and data shift logic when to present the next bit. A single 32-bit configuration word sets it up. That word holds a 10-bit divide value, a launch-edge select bit, a power-save enable and two bus-width bits. The word may be rewritten at any moment. The generator adopts a new value only at a card-clock period boundary, so a change never produces a shortened pulse.

A divide value of zero is the bypass setting: the kernel clock reaches the card unchanged and bits are launched on its falling edge. A nonzero value N gives a card clock of kernel/(2·N) with a 50% duty cycle. In that case software picks whether bits launch on the rising or the falling card-clock edge. When power-save is enabled and the bus controller reports an idle bus, the clock is parked low at the end of a period. It restarts as soon as the bus turns busy again. The decoded bus width is presented to the data path as a two-bit code.

Top module: `sdck_gen`

## Requirements
- R1: While `rst_i` is high, `card_clk_o` is low, `launch_stb_o` is 0 and `bus_width_o` is 0.
- R2: With a divide value N (config bits [9:0]) from 1 to 1023, every high phase and every low phase of `card_clk_o` lasts exactly N kernel cycles, giving a period of 2·N.
- R3: For a nonzero divide value, each high phase of `card_clk_o` has the same length as the low phase that follows it (50% duty cycle).
- R4: A divide value of 0 makes `card_clk_o` follow the kernel clock: it is high while the kernel clock is high and low while it is low. `launch_stb_o` is held at 1, which marks a falling-edge launch in every kernel cycle.
- R5: With a nonzero divide value, `launch_stb_o` is 1 for exactly the first kernel cycle after each launch edge and 0 otherwise. Config bit 16 = 0 selects the rising edge of `card_clk_o` as the launch edge, and bit 16 = 1 selects the falling edge.
- R6: `bus_width_o` decodes config bits 15 and 14: bit 15 set gives 2 (8-bit bus, taking priority over bit 14), only bit 14 set gives 1 (4-bit bus), and neither gives 0 (1-bit bus). The code 3 never appears.
- R7: A new divide value written in the middle of a period is adopted only at the next rising edge of `card_clk_o`. Every phase before that edge has the old length, and every phase from that edge onward has the new length.
- R8: When power-save (config bit 12) is set and `bus_idle_i` is 1, `card_clk_o` stops low at the end of the current period and no launch strobe is produced. With bit 12 clear, `bus_idle_i` has no effect on the clock.
- R9: When `bus_idle_i` returns to 0, a stopped card clock rises again within one card-clock period.
- R10: The largest divide value, 1023, gives phases of 1023 kernel cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_i | input | 32 | Configuration word: [9:0] divide value, 12 power-save enable, 14 4-bit bus, 15 8-bit bus, 16 falling-edge launch |
| bus_idle_i | input | 1 | High while the bus controller has no transfer in progress |
| card_clk_o | output | 1 | Clock driven to the card |
| launch_stb_o | output | 1 | One-cycle mark of a launch edge on the card clock |
| bus_width_o | output | 2 | Decoded bus width: 0 = 1-bit, 1 = 4-bit, 2 = 8-bit |

## Verification
The hardest case to produce from the ports is a divide change that lands partway through a card-clock phase. Only then does the period-boundary rule decide whether a runt pulse or a mixed-length phase appears. The bench starts a run measurement and, in a parallel thread, rewrites the divide value a random number of cycles into it, in both the up and the down direction. It then checks that the first phase with the new length is a high phase and that all the phases before it keep the old length. The parked power-save state is reached by raising the idle input with power-save enabled and waiting several periods, after which the time to restart is measured.

// File: rtl/sdck_pkg.sv
package sdck_pkg;

    localparam int CFG_W     = 32;
    localparam int CKDIV_W   = 10;
    localparam int DIV_LSB   = 0;
    localparam int PSAVE_BIT = 12;
    localparam int BW4_BIT   = 14;
    localparam int BW8_BIT   = 15;
    localparam int LATE_BIT  = 16;

    typedef enum logic [1:0] {
        BW_1 = 2'd0,
        BW_4 = 2'd1,
        BW_8 = 2'd2
    } bus_w_e;

    typedef struct packed {
        logic [CKDIV_W-1:0] div;
        logic               pwr_save;
        logic               late_edge;
        bus_w_e             width;
    } ck_cfg_t;

    // Split the configuration word into its fields; the 8-bit bit wins.
    function automatic ck_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        ck_cfg_t c;
        c.div       = w[DIV_LSB +: CKDIV_W];
        c.pwr_save  = w[PSAVE_BIT];
        c.late_edge = w[LATE_BIT];
        if (w[BW8_BIT])
            c.width = BW_8;
        else if (w[BW4_BIT])
            c.width = BW_4;
        else
            c.width = BW_1;
        return c;
    endfunction

endpackage

// File: rtl/sdck_shadow.sv
module sdck_shadow
    import sdck_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    load_i,
    input  ck_cfg_t live_i,
    output ck_cfg_t act_o
);

    // Active copy of the configuration, refreshed only when the divider
    // core reports a period boundary (or continuously in bypass).
    always_ff @(posedge clk_i) begin
        if (rst_i)
            act_o <= '0;
        else if (load_i)
            act_o <= live_i;
    end

endmodule

// File: rtl/sdck_divcore.sv
module sdck_divcore #(
    parameter int DIVW = 10
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [DIVW-1:0] cur_div_i,
    input  logic            cur_late_i,
    input  logic [DIVW-1:0] new_div_i,
    input  logic            new_late_i,
    input  logic            stop_i,
    output logic            load_o,
    output logic            ck_o,
    output logic            stb_o,
    output logic            byp_run_o
);

    logic [DIVW-1:0] cnt_q;
    logic [DIVW-1:0] cnt_d;
    logic            ck_d;
    logic            stb_d;
    logic            byp;
    logic            at_end;

    assign byp    = (cur_div_i == '0);
    assign at_end = (cnt_q == cur_div_i - 1'b1);

    // Bypass: accept config every cycle, keep the divided clock low.
    // Divided: count N cycles per phase; the end of a low phase is the
    // period boundary where config is adopted or the clock is parked.
    always_comb begin
        load_o = 1'b0;
        cnt_d  = cnt_q;
        ck_d   = ck_o;
        stb_d  = 1'b0;
        if (byp) begin
            load_o = 1'b1;
            cnt_d  = '0;
            ck_d   = 1'b0;
            stb_d  = (new_div_i == '0) && !stop_i;
        end else if (!at_end) begin
            cnt_d = cnt_q + 1'b1;
        end else if (ck_o) begin
            cnt_d = '0;
            ck_d  = 1'b0;
            stb_d = cur_late_i;
        end else if (!stop_i) begin
            load_o = 1'b1;
            cnt_d  = '0;
            if (new_div_i == '0) begin
                ck_d = 1'b0;
            end else begin
                ck_d  = 1'b1;
                stb_d = !new_late_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            ck_o  <= 1'b0;
            stb_o <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ck_o  <= ck_d;
            stb_o <= stb_d;
        end
    end

    assign byp_run_o = byp && !stop_i;

endmodule

// File: rtl/sdck_outgate.sv
module sdck_outgate (
    input  logic clk_i,
    input  logic rst_i,
    input  logic byp_run_i,
    input  logic div_ck_i,
    output logic card_clk_o
);

    logic gate_q;

    // Enable sampled while the kernel clock is low, so the AND below can
    // only open or close during a low phase: no partial pulses.
    always_ff @(negedge clk_i) begin
        if (rst_i)
            gate_q <= 1'b0;
        else
            gate_q <= byp_run_i;
    end

    assign card_clk_o = div_ck_i | (clk_i & gate_q);

endmodule

// File: rtl/sdck_gen.sv
module sdck_gen
    import sdck_pkg::*;
#(
    parameter int DIVW = CKDIV_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             bus_idle_i,
    output logic             card_clk_o,
    output logic             launch_stb_o,
    output logic [1:0]       bus_width_o
);

    ck_cfg_t   live_cfg;
    ck_cfg_t   act_cfg;
    logic      stop;
    logic      load;
    logic      div_ck;
    logic      byp_run;

    assign live_cfg = decode_cfg(cfg_i);
    assign stop     = live_cfg.pwr_save && bus_idle_i;

    sdck_shadow u_shadow (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .live_i (live_cfg),
        .act_o  (act_cfg)
    );

    sdck_divcore #(.DIVW(DIVW)) u_core (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cur_div_i  (act_cfg.div),
        .cur_late_i (act_cfg.late_edge),
        .new_div_i  (live_cfg.div),
        .new_late_i (live_cfg.late_edge),
        .stop_i     (stop),
        .load_o     (load),
        .ck_o       (div_ck),
        .stb_o      (launch_stb_o),
        .byp_run_o  (byp_run)
    );

    sdck_outgate u_gate (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .byp_run_i  (byp_run),
        .div_ck_i   (div_ck),
        .card_clk_o (card_clk_o)
    );

    assign bus_width_o = act_cfg.width;

endmodule

// File: rtl/sdck_chk.sv
module sdck_chk
    import sdck_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic               ck_q,
    input logic               stb,
    input logic [CKDIV_W-1:0] act_div,
    input logic               stop,
    input logic [1:0]         bus_w
);

    logic        ck_d;
    logic [15:0] run;

    // Length of the current level of the divided clock, in kernel cycles.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ck_d <= 1'b0;
            run  <= '0;
        end else begin
            ck_d <= ck_q;
            if (ck_q != ck_d)
                run <= 16'd1;
            else if (run != 16'hFFFF)
                run <= run + 16'd1;
        end
    end

    // R2
    high_phase_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ck_q) |-> ({6'd0, act_div} == run));

    // R7
    no_runt_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ck_q) |-> (run >= {6'd0, $past(act_div)}));

    // R4
    bypass_div_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_div == '0) |=> !ck_q);

    // R5
    rise_stb_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb && ck_q) |-> !ck_d);

    // R5
    fall_stb_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb && !ck_q && act_div != '0) |-> ck_d);

    // R8
    parked_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop && !ck_q) |=> !ck_q);

    // R6
    width_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_w != 2'd3);

endmodule

bind sdck_gen sdck_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ck_q    (div_ck),
    .stb     (launch_stb_o),
    .act_div (act_cfg.div),
    .stop    (stop),
    .bus_w   (bus_width_o)
);

// File: tb/tb_sdck_gen.sv
module tb_sdck_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg = '0;
    logic        idle = 1'b0;
    logic        card_clk;
    logic        stb;
    logic [1:0]  bus_w;

    int vec = 0;
    int bad = 0;
    bit done = 0;
    int cur_n = 0;

    int   run_len [64];
    logic run_lvl [64];
    int   nruns, stb_bad, stb_seen;

    always #4 clk = ~clk;

    sdck_gen dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .cfg_i        (cfg),
        .bus_idle_i   (idle),
        .card_clk_o   (card_clk),
        .launch_stb_o (stb),
        .bus_width_o  (bus_w)
    );

    function automatic logic [31:0] mk(input int div, input bit ps, input bit late,
                                       input bit w4, input bit w8);
        logic [31:0] w = '0;
        w[9:0] = div[9:0];
        w[12]  = ps;
        w[14]  = w4;
        w[15]  = w8;
        w[16]  = late;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [31:0] w);
        @(posedge clk);
        #1 cfg = w;
    endtask

    // Record phase lengths seen at mid-low of the kernel clock and compare
    // the strobe with the launch edge expected for the chosen edge select.
    task automatic collect(input int cyc, input bit late);
        logic prev, exp_stb;
        int   len;
        bit   started;
        nruns = 0; stb_bad = 0; stb_seen = 0; len = 0; started = 0;
        @(negedge clk); #1;
        prev = card_clk;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk); #1;
            if (card_clk !== prev) begin
                if (started && nruns < 64) begin
                    run_len[nruns] = len;
                    run_lvl[nruns] = prev;
                    nruns++;
                end
                started = 1;
                len = 1;
                exp_stb = (card_clk == !late);
            end else begin
                len++;
                exp_stb = 1'b0;
            end
            if (stb !== exp_stb) stb_bad++;
            if (stb === 1'b1) stb_seen++;
            prev = card_clk;
        end
    endtask

    task automatic run_divided(input int n, input bit late, input string req);
        int badlen, firstbad, duty_bad;
        set_cfg(mk(n, 0, late, 0, 0));
        wait_cyc(2 * cur_n + 2 * n + 6);
        cur_n = n;
        collect(6 * n + 6, late);
        check(nruns >= 4, req, nruns, 4);
        badlen = 0; firstbad = n; duty_bad = 0;
        for (int i = 0; i < nruns; i++) begin
            if (run_len[i] != n) begin
                if (badlen == 0) firstbad = run_len[i];
                badlen++;
            end
            if (run_lvl[i] == 1'b1 && i + 1 < nruns && run_len[i] != run_len[i+1])
                duty_bad++;
        end
        check(badlen == 0, req, firstbad, n);
        // R3 high phase equals following low phase
        check(duty_bad == 0, "R3", duty_bad, 0);
        // R5 strobe only on the selected launch edge
        check(stb_bad == 0 && stb_seen > 0, "R5", stb_bad, 0);
    endtask

    // R7: change divide a -> b at a random point of a measurement window
    task automatic switch_test(input int a, input int b);
        int k, after_bad, off;
        run_divided(a, 0, "R2");
        off = $urandom_range(4 * a + 3, 2);
        fork
            collect(4 * a + 8 * b + 10, 0);
            begin
                repeat (off) @(posedge clk);
                #1 cfg = mk(b, 0, 0, 0, 0);
            end
        join
        cur_n = b;
        k = -1;
        for (int i = 0; i < nruns; i++)
            if (k < 0 && run_len[i] != a) k = i;
        check(k >= 0, "R7", k, 0);
        if (k >= 0) begin
            check(run_lvl[k] == 1'b1, "R7", int'(run_lvl[k]), 1);
            after_bad = 0;
            for (int i = k; i < nruns; i++)
                if (run_len[i] != b) after_bad++;
            check(after_bad == 0, "R7", after_bad, 0);
        end
        check(stb_bad == 0, "R5", stb_bad, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            vec++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        int errs, cnt;
        void'($urandom(32'h5D1C));
        cfg = mk(5, 0, 0, 1, 1);
        wait_cyc(4);
        @(posedge clk); #2;
        // R1 reset state
        check(card_clk === 1'b0, "R1", int'(card_clk), 0);
        check(stb === 1'b0 && bus_w === 2'd0, "R1", int'(bus_w), 0);
        @(posedge clk); #1 rst = 1'b0; cfg = '0;
        wait_cyc(3);

        // R2 directed small dividers, both launch edges
        run_divided(1, 0, "R2");
        run_divided(1, 1, "R2");
        run_divided(2, 1, "R2");
        run_divided(3, 0, "R2");
        // R2 random dividers and edges
        for (int i = 0; i < 8; i++)
            run_divided($urandom_range(40, 1), $urandom_range(1, 0), "R2");
        // R10 maximum divider
        run_divided(1023, 0, "R10");
        run_divided(4, 1, "R2");

        // R7 mid-period changes in both directions
        switch_test(3, 7);
        switch_test(9, 2);

        // R4 bypass
        set_cfg(mk(0, 0, 0, 0, 0));
        wait_cyc(2 * cur_n + 6);
        cur_n = 0;
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2;
            if (card_clk !== 1'b1 || stb !== 1'b1) errs++;
            @(negedge clk); #2;
            if (card_clk !== 1'b0) errs++;
        end
        check(errs == 0, "R4", errs, 0);

        // R6 bus width decode
        set_cfg(mk(0, 0, 0, 1, 0)); wait_cyc(2);
        check(bus_w === 2'd1, "R6", int'(bus_w), 1);
        set_cfg(mk(0, 0, 0, 0, 1)); wait_cyc(2);
        check(bus_w === 2'd2, "R6", int'(bus_w), 2);
        set_cfg(mk(0, 0, 0, 1, 1)); wait_cyc(2);
        check(bus_w === 2'd2, "R6", int'(bus_w), 2);
        set_cfg(mk(0, 0, 0, 0, 0)); wait_cyc(2);
        check(bus_w === 2'd0, "R6", int'(bus_w), 0);

        // R8 idle without power-save leaves the clock running
        run_divided(4, 0, "R2");
        @(posedge clk); #1 idle = 1'b1;
        collect(40, 0);
        errs = 0;
        for (int i = 0; i < nruns; i++) if (run_len[i] != 4) errs++;
        check(nruns >= 4 && errs == 0, "R8", errs, 0);

        // R8 power-save with idle parks the clock low
        set_cfg(mk(4, 1, 0, 0, 0));
        wait_cyc(3 * 8 + 4);
        errs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (card_clk !== 1'b0 || stb !== 1'b0) errs++;
        end
        check(errs == 0, "R8", errs, 0);

        // R9 resume within one period
        @(posedge clk); #1 idle = 1'b0;
        cnt = 0;
        for (int i = 0; i < 20 && card_clk !== 1'b1; i++) begin
            @(negedge clk); #1;
            cnt++;
        end
        check(card_clk === 1'b1 && cnt <= 8, "R9", cnt, 8);
        collect(40, 0);
        errs = 0;
        for (int i = 0; i < nruns; i++) if (run_len[i] != 4) errs++;
        check(nruns >= 4 && errs == 0, "R9", errs, 0);

        // R8 power-save in bypass
        set_cfg(mk(0, 1, 0, 0, 0));
        wait_cyc(2 * 4 + 6);
        @(posedge clk); #1 idle = 1'b1;
        wait_cyc(3);
        errs = 0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #2;
            if (card_clk !== 1'b0 || stb !== 1'b0) errs++;
        end
        check(errs == 0, "R8", errs, 0);
        @(posedge clk); #1 idle = 1'b0;
        wait_cyc(3);
        @(posedge clk); #2;
        check(card_clk === 1'b1, "R9", int'(card_clk), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule